// File: doc/BRIEF.md
# Hardwired Multi-Cycle Instruction Sequencer

This block is a small processor core in which a hardwired control unit walks every instruction through six numbered timing states, T0 to T5. The first three states fetch an instruction: the program counter goes to the memory address register, the addressed word goes to the memory buffer register while the program counter advances, and the buffered word goes to the instruction register. The remaining states carry out one of three instructions on the general register R1. LOAD reads memory into R1. STORE writes R1 to memory. ADD adds R2 to R1.

Each register load is enabled by one timing state ANDed with either the fetch phase or a decoded opcode. Every transfer listed for one state lands on the same clock edge and uses the values held before that edge. The 256-word memory array sits inside the block. A test harness fills it through a preload port while reset is held, and can read any word back at any time through a combinational read-back port. The current timing state and all six registers appear on output ports.

Top module: `seq_top`

## Requirements
- R1: While `rst` is high at a rising edge, PC, MAR, MBR, IR, R1 and the timing state are cleared to zero, with T0 encoded as 0. R2 is also cleared, except as stated in R10.
- R2: In state T0 (code 0), the edge loads MAR with PC and moves the state to T1.
- R3: In state T1 (code 1), one edge loads MBR with the memory word at MAR[7:0] and loads PC with PC+1 (modulo 2^16). The state moves to T2.
- R4: In state T2 (code 2), the edge loads IR with MBR and moves the state to T3. The opcode is IR[15:12] (1 = LOAD, 2 = STORE, 3 = ADD) and the address field is IR[7:0].
- R5: In T3 with opcode ADD, R1 takes R1+R2 (modulo 2^16) and the state returns to T0.
- R6: LOAD: at T3, MAR takes the zero-extended IR[7:0]. At T4, MBR takes the memory word at MAR. At T5, R1 takes MBR. The state then returns to T0.
- R7: STORE: at T3, MAR takes the zero-extended IR[7:0]. At T4, MBR takes R1. At the T5 edge, the memory word at MAR[7:0] is written with MBR, and the state returns to T0.
- R8: In T3, any opcode other than 1, 2 or 3 changes no register and returns the state to T0.
- R9: A preload write (`pre_we`) changes memory only while `rst` is high. While `rst` is low it has no effect.
- R10: While `rst` is high, R2 takes `pre_data` if `pre_r2_we` is set, and zero otherwise. Outside reset, R2 never changes.
- R11: A register whose enable is false for the current state and opcode keeps its value across the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pre_we | input | 1 | Preload write strobe for memory, honoured only in reset |
| pre_r2_we | input | 1 | Loads R2 from `pre_data` during reset |
| pre_addr | input | 8 | Preload word address |
| pre_data | input | 16 | Preload word, also the R2 seed |
| rd_addr | input | 8 | Read-back address |
| rd_data | output | 16 | Memory word at `rd_addr`, combinational |
| state_o | output | 3 | Current timing state, T0..T5 as 0..5 |
| pc_o | output | 16 | Program counter |
| mar_o | output | 16 | Memory address register |
| mbr_o | output | 16 | Memory buffer register |
| ir_o | output | 16 | Instruction register |
| r1_o | output | 16 | General register R1 |
| r2_o | output | 16 | Operand register R2 |

## Verification
Every register transfer appears on the outputs one rising edge after the timing state that enables it. A memory write made in T5 can be seen on `rd_data` right after that edge. The bench steps its own model of the machine once per rising edge, then compares the state and all six registers at the following falling edge, so each result is checked in exactly the cycle it falls due. Memory contents and ignored preload writes are checked through the read-back port while reset holds the core still. Each readback address is settled for half a cycle before it is sampled.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        ST_T0 = 3'd0,
        ST_T1 = 3'd1,
        ST_T2 = 3'd2,
        ST_T3 = 3'd3,
        ST_T4 = 3'd4,
        ST_T5 = 3'd5
    } tstate_e;

    localparam logic [3:0] OPC_LOAD  = 4'd1;
    localparam logic [3:0] OPC_STORE = 4'd2;
    localparam logic [3:0] OPC_ADD   = 4'd3;

    // one load enable per micro-operation
    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic mbr_from_mem;
        logic mbr_from_r1;
        logic pc_step;
        logic ir_from_mbr;
        logic r1_sum;
        logic r1_from_mbr;
        logic mem_write;
    } xfer_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic [3:0]   opcode,
    output tstate_e      state,
    output xfer_t        xfer
);

    tstate_e state_nx;
    logic    is_load, is_store, is_add;

    assign is_load  = (opcode == OPC_LOAD);
    assign is_store = (opcode == OPC_STORE);
    assign is_add   = (opcode == OPC_ADD);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_T0;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = ST_T0;
        unique case (state)
            ST_T0: state_nx = ST_T1;
            ST_T1: state_nx = ST_T2;
            ST_T2: state_nx = ST_T3;
            ST_T3: state_nx = (is_load || is_store) ? ST_T4 : ST_T0;
            ST_T4: state_nx = ST_T5;
            ST_T5: state_nx = ST_T0;
            default: state_nx = ST_T0;
        endcase
    end

    // each enable: one timing state AND phase/opcode condition
    always_comb begin
        xfer = '0;
        unique case (state)
            ST_T0: xfer.mar_from_pc = 1'b1;
            ST_T1: begin
                xfer.mbr_from_mem = 1'b1;
                xfer.pc_step      = 1'b1;
            end
            ST_T2: xfer.ir_from_mbr = 1'b1;
            ST_T3: begin
                xfer.r1_sum      = is_add;
                xfer.mar_from_ir = is_load || is_store;
            end
            ST_T4: begin
                xfer.mbr_from_mem = is_load;
                xfer.mbr_from_r1  = is_store;
            end
            ST_T5: begin
                xfer.r1_from_mbr = is_load;
                xfer.mem_write   = is_store;
            end
            default: xfer = '0;
        endcase
    end

    AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_T0) |=> (state == ST_T1)); // R2
    AST_ODD_OPCODE_RETURN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_T3 && !is_load && !is_store) |=> (state == ST_T0)); // R8
    AST_EXEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_T5) |=> (state == ST_T0)); // R6
    AST_ONE_MBR_SOURCE: assert property (@(posedge clk) disable iff (rst)
        !(xfer.mbr_from_mem && xfer.mbr_from_r1)); // R11

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
    import seq_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pre_r2_we,
    input  logic [DW-1:0] pre_data,
    input  xfer_t         xfer,
    input  logic [DW-1:0] mem_q,
    output logic [DW-1:0] pc,
    output logic [DW-1:0] mar,
    output logic [DW-1:0] mbr,
    output logic [DW-1:0] ir,
    output logic [DW-1:0] r1,
    output logic [DW-1:0] r2
);

    localparam int ADDR_PAD = DW - AW;

    logic [DW-1:0] ir_addr;
    assign ir_addr = {{ADDR_PAD{1'b0}}, ir[AW-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            mar <= '0;
            mbr <= '0;
            ir  <= '0;
            r1  <= '0;
            r2  <= pre_r2_we ? pre_data : '0;
        end else begin
            if (xfer.mar_from_pc)       mar <= pc;
            else if (xfer.mar_from_ir)  mar <= ir_addr;
            if (xfer.mbr_from_mem)      mbr <= mem_q;
            else if (xfer.mbr_from_r1)  mbr <= r1;
            if (xfer.pc_step)           pc  <= pc + 1'b1;
            if (xfer.ir_from_mbr)       ir  <= mbr;
            if (xfer.r1_sum)            r1  <= r1 + r2;
            else if (xfer.r1_from_mbr)  r1  <= mbr;
        end
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        xfer.pc_step |=> (pc == $past(pc) + 1'b1)); // R3
    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !xfer.ir_from_mbr |=> $stable(ir)); // R11
    AST_R2_FROZEN: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(r2)); // R10
    AST_SUM_LANDS: assert property (@(posedge clk) disable iff (rst)
        xfer.r1_sum |=> (r1 == $past(r1) + $past(r2))); // R5

endmodule

// File: rtl/seq_mem.sv
module seq_mem #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [DW-1:0] pre_data,
    input  logic          st_we,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic [AW-1:0] core_addr,
    output logic [DW-1:0] core_q,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_q
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    // preload owns the port during reset, the core otherwise
    always_comb begin
        if (rst) begin
            wr_en   = pre_we;
            wr_addr = pre_addr;
            wr_data = pre_data;
        end else begin
            wr_en   = st_we;
            wr_addr = st_addr;
            wr_data = st_data;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) words[wr_addr] <= wr_data;
    end

    assign core_q = words[core_addr];
    assign rd_q   = words[rd_addr];

    AST_STORE_LANDS: assert property (@(posedge clk) disable iff (rst)
        st_we |=> (words[$past(st_addr)] == $past(st_data))); // R7

endmodule

// File: rtl/seq_top.sv
module seq_top
    import seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pre_we,
    input  logic        pre_r2_we,
    input  logic [7:0]  pre_addr,
    input  logic [15:0] pre_data,
    input  logic [7:0]  rd_addr,
    output logic [15:0] rd_data,
    output logic [2:0]  state_o,
    output logic [15:0] pc_o,
    output logic [15:0] mar_o,
    output logic [15:0] mbr_o,
    output logic [15:0] ir_o,
    output logic [15:0] r1_o,
    output logic [15:0] r2_o
);

    localparam int DW = 16;
    localparam int AW = 8;
    localparam int OPC_W = 4;

    tstate_e       state;
    xfer_t         xfer;
    logic [DW-1:0] mem_q;

    seq_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .opcode (ir_o[DW-1 -: OPC_W]),
        .state  (state),
        .xfer   (xfer)
    );

    seq_datapath #(.DW(DW), .AW(AW)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .pre_r2_we (pre_r2_we),
        .pre_data  (pre_data),
        .xfer      (xfer),
        .mem_q     (mem_q),
        .pc        (pc_o),
        .mar       (mar_o),
        .mbr       (mbr_o),
        .ir        (ir_o),
        .r1        (r1_o),
        .r2        (r2_o)
    );

    seq_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk       (clk),
        .rst       (rst),
        .pre_we    (pre_we),
        .pre_addr  (pre_addr),
        .pre_data  (pre_data),
        .st_we     (xfer.mem_write),
        .st_addr   (mar_o[AW-1:0]),
        .st_data   (mbr_o),
        .core_addr (mar_o[AW-1:0]),
        .core_q    (mem_q),
        .rd_addr   (rd_addr),
        .rd_q      (rd_data)
    );

    assign state_o = state;

endmodule

// File: tb/sim_seq_top.sv
module sim_seq_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pre_we = 1'b0;
    logic        pre_r2_we = 1'b0;
    logic [7:0]  pre_addr = '0;
    logic [15:0] pre_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [2:0]  state_o;
    logic [15:0] pc_o, mar_o, mbr_o, ir_o, r1_o, r2_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    int          m_state;
    logic [15:0] m_pc, m_mar, m_mbr, m_ir, m_r1, m_r2;
    logic [15:0] m_mem [256];
    string       m_tag;

    always #(CLK_P/2) clk = ~clk;

    seq_top u0 (
        .clk(clk), .rst(rst), .pre_we(pre_we), .pre_r2_we(pre_r2_we),
        .pre_addr(pre_addr), .pre_data(pre_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .state_o(state_o), .pc_o(pc_o), .mar_o(mar_o),
        .mbr_o(mbr_o), .ir_o(ir_o), .r1_o(r1_o), .r2_o(r2_o)
    );

    function automatic string tag_for(bit r, int st, logic [3:0] op);
        if (r) return "R1";
        case (st)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: begin
                if (op == 4'd1) return "R6";
                if (op == 4'd2) return "R7";
                if (op == 4'd3) return "R5";
                return "R8";
            end
        endcase
    endfunction

    task automatic model_step();
        logic [3:0]  op;
        int          ns;
        logic [15:0] n_pc, n_mar, n_mbr, n_ir, n_r1;
        op    = m_ir[15:12];
        m_tag = tag_for(rst, m_state, op);
        if (rst) begin
            m_state = 0; m_pc = '0; m_mar = '0; m_mbr = '0; m_ir = '0; m_r1 = '0;
            m_r2 = pre_r2_we ? pre_data : 16'h0;
            if (pre_we) m_mem[pre_addr] = pre_data;
        end else begin
            n_pc = m_pc; n_mar = m_mar; n_mbr = m_mbr; n_ir = m_ir; n_r1 = m_r1;
            ns = 0;
            case (m_state)
                0: begin n_mar = m_pc; ns = 1; end
                1: begin n_mbr = m_mem[m_mar[7:0]]; n_pc = m_pc + 16'd1; ns = 2; end
                2: begin n_ir = m_mbr; ns = 3; end
                3: begin
                    if (op == 4'd3) n_r1 = m_r1 + m_r2;
                    if (op == 4'd1 || op == 4'd2) begin
                        n_mar = {8'h00, m_ir[7:0]}; ns = 4;
                    end
                end
                4: begin
                    if (op == 4'd1) n_mbr = m_mem[m_mar[7:0]];
                    if (op == 4'd2) n_mbr = m_r1;
                    ns = 5;
                end
                default: begin
                    if (op == 4'd1) n_r1 = m_mbr;
                    if (op == 4'd2) m_mem[m_mar[7:0]] = m_mbr;
                end
            endcase
            m_state = ns; m_pc = n_pc; m_mar = n_mar; m_mbr = n_mbr;
            m_ir = n_ir; m_r1 = n_r1;
        end
    endtask

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_regs();
        check(m_tag, "state", {13'h0, state_o}, m_state[15:0]);
        check(m_tag, "pc",  pc_o,  m_pc);
        check(m_tag, "mar", mar_o, m_mar);
        check(m_tag, "mbr", mbr_o, m_mbr);
        check(m_tag, "ir",  ir_o,  m_ir);
        check(m_tag, "r1",  r1_o,  m_r1);
        check("R10", "r2",  r2_o,  m_r2);
    endtask

    // one rising edge, model update, compare at the falling edge
    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_regs();
    endtask

    task automatic preload(int idx, logic [15:0] w);
        rst = 1'b1; pre_we = 1'b1; pre_addr = idx[7:0]; pre_data = w;
        cycle();
        pre_we = 1'b0;
    endtask

    task automatic readback_all(string req);
        rst = 1'b1; pre_we = 1'b0;
        for (int a = 0; a < 256; a++) begin
            rd_addr = a[7:0];
            #(CLK_P/2);
            check(req, "mem", rd_data, m_mem[a]);
            #(CLK_P/2);
        end
    endtask

    function automatic logic [15:0] rand_instr();
        logic [3:0] op;
        op = 4'($urandom_range(0, 5));
        return {op, 4'($urandom), 8'($urandom)};
    endfunction

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int a = 0; a < 256; a++) m_mem[a] = 16'h0;
        @(negedge clk);
        // R1: reset state
        rst = 1'b1;
        cycle();
        // directed program
        for (int a = 0; a < 256; a++) preload(a, 16'h0000);
        preload(0, 16'h1080);  // LOAD 80
        preload(1, 16'h3000);  // ADD (carry out dropped)
        preload(2, 16'h2081);  // STORE 81
        preload(3, 16'h0000);  // unknown opcode 0
        preload(4, 16'h5123);  // unknown opcode 5
        preload(5, 16'h1081);  // LOAD 81
        preload(6, 16'h3000);  // ADD
        preload(7, 16'h20FF);  // STORE FF
        preload(8'h80, 16'h7FFF);
        rst = 1'b1; pre_r2_we = 1'b1; pre_data = 16'h8002;
        cycle();
        pre_r2_we = 1'b0; rst = 1'b0;
        check("R10", "r2 seed", r2_o, 16'h8002);
        for (int i = 0; i < 60; i++) begin
            // R9: preload strobe outside reset must be ignored
            pre_we = (i % 7 == 3); pre_addr = 8'h90; pre_data = 16'hDEAD;
            cycle();
        end
        pre_we = 1'b0;
        readback_all("R7");
        rd_addr = 8'h81; #1; check("R7", "store 81", rd_data, 16'h0001);
        rd_addr = 8'hFF; #1; check("R7", "store FF", rd_data, 16'h8003);
        rd_addr = 8'h90; #1; check("R9", "ignored preload", rd_data, 16'h0000);
        @(negedge clk);
        // random programs
        for (int run = 0; run < 3; run++) begin
            for (int a = 0; a < 256; a++) preload(a, rand_instr());
            rst = 1'b1; pre_r2_we = 1'b1; pre_data = 16'($urandom);
            cycle();
            pre_r2_we = 1'b0; rst = 1'b0;
            for (int i = 0; i < 3000; i++) begin
                pre_we = ($urandom_range(0, 15) == 0);
                pre_addr = 8'($urandom); pre_data = 16'($urandom);
                cycle();
            end
            pre_we = 1'b0;
            readback_all("R9");
            @(negedge clk);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule